// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block is a supervision timer. Software has to restart it within a programmed interval, and if it does not, the block sends a single-cycle timeout pulse to the chip's reset logic. The oscillator clock goes through a free-running divider chain that produces a one-cycle count enable. The chain is a divide-by-12 stage followed by a divide-by-2 stage and a divide-by-16 stage, and two select inputs can bypass each of the last two stages. The enable drives a 15-bit up-counter. Its upper 7 bits are preloaded from a reload value, and its lower 8 bits always start from zero.

A restart has two steps. Software pulses the arm strobe, then pulses the fire strobe in the very next cycle. Any other order, any gap between the two, or both strobes in the same cycle leaves the counter untouched. When the counter steps past its all-ones value, the block emits the timeout pulse and continues counting from the reload value, so the pulses repeat until software refreshes the counter. The reload value and the select bits are held in a control register outside this block, and that register resets to the longest timeout at divide-by-24.

Top module: `wdog_timer`

## Requirements
- R1: The inputs (`half_rate_i`, `slow_rate_i`) set the number of clock cycles between count enables: (0,0) gives 12, (0,1) gives 192, (1,0) gives 24 and (1,1) gives 384.
- R2: The prescaler runs freely and a refresh does not restart it. Each count enable lasts exactly one cycle, and the time between consecutive timeout pulses is exactly 256·(128−reload)·divide cycles.
- R3: An asynchronous active-low `rst_n` clears the counter to zero and holds `timeout_o` low. After reset, `timeout_o` stays low until the counter completes its longest period.
- R4: A refresh happens only when `kick_fire_i` is high in the cycle directly after a cycle in which `kick_arm_i` was high and `kick_fire_i` was low. A fire strobe on its own, a fire strobe after a gap, a fire strobe before the arm strobe, and both strobes in the same cycle all have no effect on the count.
- R5: A refresh loads the 7-bit `reload_i` into count bits 14:8 and clears count bits 7:0 in the same cycle. A refresh takes priority over a count enable in that cycle.
- R6: Starting from a refresh, the counter overflows after 256·(128−reload) count enables: 256 for reload 0x7F, 512 for 0x7E and 32768 for 0x00.
- R7: When a count enable arrives while the counter holds 0x7FFF, `timeout_o` goes high for exactly one cycle, starting in the cycle after that clock edge. In the same edge the counter reloads to {reload, 0x00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_rate_i | input | 1 | Enables the divide-by-2 prescaler stage |
| slow_rate_i | input | 1 | Enables the divide-by-16 prescaler stage |
| reload_i | input | 7 | Value loaded into the upper count bits on refresh and on overflow |
| kick_arm_i | input | 1 | First strobe of the refresh sequence |
| kick_fire_i | input | 1 | Second strobe of the refresh sequence |
| timeout_o | output | 1 | One-cycle timeout pulse |

## Verification
The hardest case to reach is a refused refresh, because its only visible effect is that nothing changes. To reach it, the stimulus starts a long countdown with a valid refresh, then applies every malformed strobe pattern well before the expected overflow. It then requires the timeout to arrive inside the window that the first refresh predicts. In the same way, a second valid refresh issued mid-count must move the timeout later by a full period, which only happens if the low byte was cleared. Because the prescaler phase is free-running, the first timeout after a refresh is checked against a window one divide wide, and the following auto-reloaded pulse is checked for its exact spacing.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int LO_W  = 8;
  localparam int HI_W  = 7;
  localparam int CNT_W = LO_W + HI_W;

  // Count word produced by a refresh or an overflow: reload on top, zero low byte.
  function automatic logic [CNT_W-1:0] wd_start_word(input logic [HI_W-1:0] rel);
    return {rel, {LO_W{1'b0}}};
  endfunction

  function automatic logic wd_at_top(input logic [CNT_W-1:0] cnt);
    return &cnt;
  endfunction

  function automatic logic [CNT_W-1:0] wd_step(input logic [CNT_W-1:0] cnt);
    return cnt + 1'b1;
  endfunction
endpackage

// File: rtl/wdog_div_stage.sv
module wdog_div_stage #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic bypass_i,
  output logic pulse_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (step_i) begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  // The stage keeps counting even while bypassed, so a change of selection
  // never lengthens the gap to the next pulse beyond one full division.
  assign pulse_o = step_i && (bypass_i || (phase_q == LAST));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int BASE_DIV = 12,
  parameter int MID_DIV  = 2,
  parameter int SLOW_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_rate_i,
  input  logic slow_rate_i,
  output logic tick_o
);
  localparam int NSTG = 3;
  localparam int STG_DIV [NSTG] = '{BASE_DIV, MID_DIV, SLOW_DIV};
  localparam int MAX_PERIOD = BASE_DIV * MID_DIV * SLOW_DIV;
  localparam int GAP_W = $clog2(MAX_PERIOD + 1) + 1;

  logic [NSTG:0]   chain;
  logic [NSTG-1:0] bypass;

  assign chain[0] = 1'b1;
  assign bypass   = {~slow_rate_i, ~half_rate_i, 1'b0};

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    wdog_div_stage #(.DIV(STG_DIV[g])) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (chain[g]),
      .bypass_i (bypass[g]),
      .pulse_o  (chain[g+1])
    );
  end

  assign tick_o = chain[NSTG];

  // Cycles since the last enable, for the spacing check.
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (tick_o) gap_q <= '0;
    else             gap_q <= gap_q + 1'b1;
  end

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GAP_W'(MAX_PERIOD));

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_kick_seq.sv
module wdog_kick_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_arm_i,
  input  logic kick_fire_i,
  output logic refresh_o
);
  logic armed_q;

  // Armed for exactly one cycle after a clean arm strobe; anything else disarms.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= kick_arm_i && !kick_fire_i;
  end

  assign refresh_o = armed_q && kick_fire_i;

  assert_refresh_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |-> ($past(kick_arm_i) && !$past(kick_fire_i)));

  assert_refresh_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |=> !refresh_o);
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            refresh_i,
  input  logic [HI_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic            wrap_o,
  output logic            timeout_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             to_q;
  logic             wrap_ev;

  // A refresh in the same cycle as the last enable suppresses the overflow.
  assign wrap_ev = tick_i && !refresh_i && wd_at_top(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      to_q <= wrap_ev;
      if (refresh_i)    cnt_q <= wd_start_word(reload_i);
      else if (wrap_ev) cnt_q <= wd_start_word(reload_i);
      else if (tick_i)  cnt_q <= wd_step(cnt_q);
    end
  end

  assign count_o   = cnt_q;
  assign wrap_o    = wrap_ev;
  assign timeout_o = to_q;

  assert_refresh_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_i |=> (cnt_q[CNT_W-1:LO_W] == $past(reload_i)) && (cnt_q[LO_W-1:0] == '0));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !refresh_i) |=> $stable(cnt_q));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |=> !to_q);

  assert_pulse_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> ($past(cnt_q) == {CNT_W{1'b1}}) && $past(tick_i));

  assert_wrap_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> (cnt_q == {$past(reload_i), {LO_W{1'b0}}}));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int BASE_DIV = 12,
  parameter int MID_DIV  = 2,
  parameter int SLOW_DIV = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            half_rate_i,
  input  logic            slow_rate_i,
  input  logic [HI_W-1:0] reload_i,
  input  logic            kick_arm_i,
  input  logic            kick_fire_i,
  output logic            timeout_o
);
  logic             tick_w;
  logic             refresh_w;
  logic             wrap_w;
  logic [CNT_W-1:0] count_w;

  wdog_prescaler #(
    .BASE_DIV (BASE_DIV),
    .MID_DIV  (MID_DIV),
    .SLOW_DIV (SLOW_DIV)
  ) u_presc (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_rate_i (half_rate_i),
    .slow_rate_i (slow_rate_i),
    .tick_o      (tick_w)
  );

  wdog_kick_seq u_kick (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick_arm_i  (kick_arm_i),
    .kick_fire_i (kick_fire_i),
    .refresh_o   (refresh_w)
  );

  wdog_count u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_w),
    .refresh_i (refresh_w),
    .reload_i  (reload_i),
    .count_o   (count_w),
    .wrap_o    (wrap_w),
    .timeout_o (timeout_o)
  );

  assert_wrap_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_w |-> (tick_w && !refresh_w && (count_w == {CNT_W{1'b1}})));

  assert_refresh_no_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_w |=> !timeout_o);
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_rate_i = 1'b0;
  logic       slow_rate_i = 1'b0;
  logic [6:0] reload_i = 7'h7F;
  logic       kick_arm_i = 1'b0;
  logic       kick_fire_i = 1'b0;
  logic       timeout_o;

  always #2 clk = ~clk;

  wdog_timer u_wdog_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_rate_i (half_rate_i),
    .slow_rate_i (slow_rate_i),
    .reload_i    (reload_i),
    .kick_arm_i  (kick_arm_i),
    .kick_fire_i (kick_fire_i),
    .timeout_o   (timeout_o)
  );

  typedef struct {
    string tag;
    bit    rel;
    int    lo;
    int    hi;
  } exp_t;

  exp_t expq[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   last_to = 0;
  bit   prev_to = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int n_ticks(input int rel);
    return 256 * (128 - rel);
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on each rising timeout and checks pulse width.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (timeout_o && prev_to)
        check("R7 pulse width", 1'b0, 2, 1);
      else if (!timeout_o && prev_to)
        check("R7 pulse width", 1'b1, 1, 1);
      if (timeout_o && !prev_to) begin
        if (expq.size() == 0) begin
          check("R4 unexpected timeout", 1'b0, cyc, 0);
        end else begin
          exp_t e;
          int   m;
          e = expq.pop_front();
          m = e.rel ? (cyc - last_to) : cyc;
          check(e.tag, (m >= e.lo) && (m <= e.hi), m, e.hi);
        end
        last_to = cyc;
      end
      prev_to = timeout_o;
    end
  end

  // Driver: two-step refresh, returns the cycle at which it took effect.
  task automatic do_refresh(output int e);
    @(negedge clk); kick_arm_i = 1'b1;
    @(negedge clk); kick_arm_i = 1'b0; kick_fire_i = 1'b1;
    @(posedge clk); #1 e = cyc;
    @(negedge clk); kick_fire_i = 1'b0;
  endtask

  task automatic expect_first(input string tag, input int div, input int rel, input int e);
    exp_t x;
    x.tag = tag; x.rel = 1'b0;
    x.lo = e + (n_ticks(rel) - 1) * div + 1;
    x.hi = e + n_ticks(rel) * div;
    expq.push_back(x);
  endtask

  task automatic expect_period(input string tag, input int div, input int rel);
    exp_t x;
    x.tag = tag; x.rel = 1'b1;
    x.lo = n_ticks(rel) * div;
    x.hi = n_ticks(rel) * div;
    expq.push_back(x);
  endtask

  task automatic drain();
    while (expq.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input bit a, input bit f);
    @(negedge clk); kick_arm_i = a; kick_fire_i = f;
    @(negedge clk); kick_arm_i = 1'b0; kick_fire_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int e;
    int seen;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R3 timeout low in reset", timeout_o == 1'b0, timeout_o, 0);
    rst_n = 1'b1;
    seen = 0;
    repeat (60) begin
      @(negedge clk);
      if (timeout_o) seen++;
    end
    check("R3 no timeout after reset", seen == 0, seen, 0);

    // /12, reload 0x7F: first window, then exact auto-reload spacing
    do_refresh(e);
    expect_first("R1 R6 div12 reload 7F", 12, 7'h7F, e);
    expect_period("R2 R7 period div12 reload 7F", 12, 7'h7F);
    drain();

    // /12, reload 0x7E with malformed strobe patterns that must be ignored
    reload_i = 7'h7E;
    do_refresh(e);
    expect_first("R4 R6 div12 reload 7E ignores bad strobes", 12, 7'h7E, e);
    repeat (500) @(posedge clk);
    strobe(1'b0, 1'b1);                       // fire alone
    repeat (20) @(posedge clk);
    strobe(1'b1, 1'b0); strobe(1'b0, 1'b0);   // arm, gap
    strobe(1'b0, 1'b1);                       // then fire
    repeat (20) @(posedge clk);
    strobe(1'b0, 1'b1); strobe(1'b1, 1'b0);   // reversed order
    repeat (20) @(posedge clk);
    strobe(1'b1, 1'b1); strobe(1'b0, 1'b1);   // both together, then fire
    drain();

    // Second refresh mid-count restarts a full period (low byte cleared)
    reload_i = 7'h7F;
    do_refresh(e);
    repeat (1500) @(posedge clk);
    do_refresh(e);
    expect_first("R5 restart from second refresh", 12, 7'h7F, e);
    drain();

    half_rate_i = 1'b1; slow_rate_i = 1'b0;
    do_refresh(e);
    expect_first("R1 div24", 24, 7'h7F, e);
    drain();

    half_rate_i = 1'b0; slow_rate_i = 1'b1;
    do_refresh(e);
    expect_first("R1 div192", 192, 7'h7F, e);
    drain();

    half_rate_i = 1'b1; slow_rate_i = 1'b1;
    do_refresh(e);
    expect_first("R1 div384", 384, 7'h7F, e);
    drain();

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule